// File: doc/BRIEF.md
# Quasi-Resonant Valley Turn-On Controller

This block decides the clock cycle in which a flyback power switch is turned on. It receives three digitized comparator flags from the sensed auxiliary-winding voltage: above the arming level, above the trigger level, and above the 1 V blank-select level. It also receives a turn-off event from the current-mode PWM path. It produces a one-cycle gate-on request. A rising ring that is above the arming level arms the detector. A later fall below the trigger level is a valley. After a fixed delay, the valley turns the switch on, but only once one period of an internal limit oscillator has passed since the previous turn-on. Valleys that come earlier are dropped, and the detector must arm again. The effect is valley skipping at light load, with the switching frequency capped at the limit.

Detection is blanked for a while after every turn-off. The blanking length is short or long, chosen by the 1 V level sampled at a fixed strobe point inside the blank window. Two fallbacks exist. If the detector is still unarmed at eight limit periods, a starter fires the switch. If the detector stays armed with no valley, the switch fires at sixty-four limit periods. The block works as a state machine with states IDLE, ON, BLANK, WAIT_ARM, WAIT_TRIG and DELAY. Its transitions are:

- enable (IDLE to WAIT_ARM)
- off_seen (ON to BLANK)
- blank_end (BLANK to WAIT_ARM)
- arm (WAIT_ARM to WAIT_TRIG)
- early_valley (WAIT_TRIG to WAIT_ARM)
- late_valley (WAIT_TRIG to DELAY)
- starter_fire (WAIT_ARM to ON)
- fallback_fire (WAIT_TRIG to ON)
- delay_fire (DELAY to ON)
- disable (any state to IDLE)

All times are parameters in clock cycles. STROBE_CYC must be less than BLANK_SHORT_CYC-1.

Top module: `qr_turnon_ctrl`

## Requirements
Below, edge n means the n-th rising clock edge after the edge that raised gate_on_o (or after the first edge with enable_i high). The phase counter equals n-1 during the cycle that ends at edge n.
- R1: In WAIT_ARM, zcd_arm_i=1 at an edge arms the detector. Only when armed does zcd_trig_i=0 at an edge count as a valley. A fall below the trigger level without prior arming causes no turn-on.
- R2: A valley seen at an edge n with n-1 < LIM_CYC is dropped. The detector disarms and needs a new zcd_arm_i=1 before a later valley is taken.
- R3: A valley seen at an edge n with n-1 >= LIM_CYC is accepted (the boundary n = LIM_CYC+1 included). The phase counter restarts at every turn-on.
- R4: A turn-off seen at edge T starts blanking. When zcd_lvl_i=1 at the strobe edge T+STROBE_CYC+1, arming is possible from edge T+BLANK_SHORT_CYC+1. Comparator edges before that point are ignored.
- R5: When zcd_lvl_i=0 at the strobe edge, blanking is long and arming is possible only from edge T+BLANK_LONG_CYC+1.
- R6: An accepted valley at edge n raises gate_on_o after edge n+DELAY_CYC.
- R7: When the detector is unarmed and the phase counter reaches 8*LIM_CYC, the starter raises gate_on_o after edge 8*LIM_CYC+1.
- R8: When the detector stays armed with no valley, gate_on_o rises after edge 64*LIM_CYC+1.
- R9: gate_on_o is a one-cycle pulse. After it, no turn-on occurs until a turn-off is seen.
- R10: pwm_off_i is ignored in every state except ON.
- R11: enable_i=0 forces gate_on_o to 0 in the same cycle and returns the block to IDLE. This clears the armed state, the blanking timer and the oscillator phase, so after re-enable the starter timing counts from the first enabled edge.
- R12: While rst_n is low, and while enable_i stays low after reset, gate_on_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run enable; low forces idle |
| zcd_arm_i | input | 1 | Sensed winding voltage above arming level |
| zcd_trig_i | input | 1 | Sensed winding voltage above trigger level (0 = below) |
| zcd_lvl_i | input | 1 | Sensed winding voltage above 1 V blank-select level |
| pwm_off_i | input | 1 | Turn-off event from the PWM path |
| gate_on_o | output | 1 | One-cycle turn-on request |

## Verification
The hardest situation to reach is a valley that falls exactly at the limit-oscillator boundary. One cycle earlier it must be skipped; at the boundary it must be accepted. That outcome depends on the on time, the chosen blanking length and the ring phase all at once. The stimulus table therefore drives rings whose start and high/low lengths place the first valley one edge before and exactly at LIM_CYC+1. It also places valleys inside the long blank window, where only the strobed 1 V level changes the outcome.

// File: rtl/qr_pkg.sv
package qr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ON        = 3'd1,
        ST_BLANK     = 3'd2,
        ST_WAIT_ARM  = 3'd3,
        ST_WAIT_TRIG = 3'd4,
        ST_DELAY     = 3'd5
    } qr_state_e;

    localparam int unsigned STARTER_DIV  = 8;
    localparam int unsigned FALLBACK_DIV = 64;

endpackage

// File: rtl/qr_phase_osc.sv
module qr_phase_osc #(
    parameter int unsigned LIM_CYC      = 735,
    parameter int unsigned STARTER_DIV  = 8,
    parameter int unsigned FALLBACK_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic lim_done,
    output logic starter_due,
    output logic fallback_due
);

    localparam int unsigned CAP     = LIM_CYC * FALLBACK_DIV;
    localparam int unsigned START_N = LIM_CYC * STARTER_DIV;
    localparam int unsigned W       = $clog2(CAP + 1);

    localparam logic [W-1:0] CAP_V   = W'(CAP);
    localparam logic [W-1:0] START_V = W'(START_N);
    localparam logic [W-1:0] LIM_V   = W'(LIM_CYC);

    logic [W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr) begin
            phase_q <= '0;
        end else if (phase_q != CAP_V) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    always_comb begin
        lim_done     = (phase_q >= LIM_V);
        starter_due  = (phase_q >= START_V);
        fallback_due = (phase_q >= CAP_V);
    end

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (phase_q == '0)) else $error("phase not restarted");  // R3

    AST_FALLBACK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        fallback_due |-> (starter_due && lim_done)) else $error("phase ordering");  // R8

endmodule

// File: rtl/qr_blank_timer.sv
module qr_blank_timer #(
    parameter int unsigned BLANK_SHORT_CYC = 250,
    parameter int unsigned BLANK_LONG_CYC  = 630,
    parameter int unsigned STROBE_CYC      = 220
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    input  logic zcd_lvl,
    output logic done,
    output logic long_sel
);

    localparam int unsigned W = $clog2(BLANK_LONG_CYC + 1);

    localparam logic [W-1:0] SHORT_END = W'(BLANK_SHORT_CYC - 1);
    localparam logic [W-1:0] LONG_END  = W'(BLANK_LONG_CYC - 1);
    localparam logic [W-1:0] STROBE_V  = W'(STROBE_CYC);
    localparam logic [W-1:0] CNT_MAX   = W'(BLANK_LONG_CYC);

    logic [W-1:0] cnt_q;
    logic         long_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            long_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= '0;
            long_q <= 1'b0;
        end else if (run) begin
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (cnt_q == STROBE_V) begin
                long_q <= !zcd_lvl;
            end
        end
    end

    always_comb begin
        done     = run && (((cnt_q == SHORT_END) && !long_q) || (cnt_q == LONG_END));
        long_sel = long_q;
    end

    AST_BLANK_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && (cnt_q > STROBE_V)) |=> $stable(long_q)) else $error("blank select moved");  // R5

    AST_BLANK_SHORT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (cnt_q < SHORT_END)) |-> !done) else $error("blank ended early");  // R4

endmodule

// File: rtl/qr_valley_delay.sv
module qr_valley_delay #(
    parameter int unsigned DELAY_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);

    generate
        if (DELAY_CYC <= 1) begin : g_direct
            assign done = run;
        end else begin : g_count
            localparam int unsigned W = $clog2(DELAY_CYC);
            localparam logic [W-1:0] END_V = W'(DELAY_CYC - 1);
            logic [W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (start) begin
                    cnt_q <= '0;
                end else if (run && (cnt_q != END_V)) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign done = run && (cnt_q == END_V);
        end
    endgenerate

    AST_DELAY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("delay fired twice");  // R6

endmodule

// File: rtl/qr_turnon_ctrl.sv
module qr_turnon_ctrl #(
    parameter int unsigned LIM_CYC         = 735,
    parameter int unsigned BLANK_SHORT_CYC = 250,
    parameter int unsigned BLANK_LONG_CYC  = 630,
    parameter int unsigned STROBE_CYC      = 220,
    parameter int unsigned DELAY_CYC       = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic zcd_arm_i,
    input  logic zcd_trig_i,
    input  logic zcd_lvl_i,
    input  logic pwm_off_i,
    output logic gate_on_o
);

    import qr_pkg::*;

    qr_state_e state_q;
    qr_state_e state_d;
    logic      fire;
    logic      gate_q;
    logic      lim_done;
    logic      starter_due;
    logic      fallback_due;
    logic      blank_done;
    logic      blank_long;
    logic      dly_done;
    logic      blank_start;
    logic      dly_start;
    logic      armed;

    qr_phase_osc #(
        .LIM_CYC      (LIM_CYC),
        .STARTER_DIV  (STARTER_DIV),
        .FALLBACK_DIV (FALLBACK_DIV)
    ) i_osc (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (fire || (state_q == ST_IDLE)),
        .lim_done     (lim_done),
        .starter_due  (starter_due),
        .fallback_due (fallback_due)
    );

    qr_blank_timer #(
        .BLANK_SHORT_CYC (BLANK_SHORT_CYC),
        .BLANK_LONG_CYC  (BLANK_LONG_CYC),
        .STROBE_CYC      (STROBE_CYC)
    ) i_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (blank_start),
        .run      (state_q == ST_BLANK),
        .zcd_lvl  (zcd_lvl_i),
        .done     (blank_done),
        .long_sel (blank_long)
    );

    qr_valley_delay #(
        .DELAY_CYC (DELAY_CYC)
    ) i_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dly_start),
        .run   (state_q == ST_DELAY),
        .done  (dly_done)
    );

    // next-state and turn-on decision
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_WAIT_ARM;
            end
            ST_ON: begin
                if (pwm_off_i) begin
                    state_d = ST_BLANK;
                end
            end
            ST_BLANK: begin
                if (blank_done) begin
                    state_d = ST_WAIT_ARM;
                end
            end
            ST_WAIT_ARM: begin
                if (starter_due) begin
                    fire    = 1'b1;
                    state_d = ST_ON;
                end else if (zcd_arm_i) begin
                    state_d = ST_WAIT_TRIG;
                end
            end
            ST_WAIT_TRIG: begin
                if (fallback_due) begin
                    fire    = 1'b1;
                    state_d = ST_ON;
                end else if (!zcd_trig_i) begin
                    state_d = lim_done ? ST_DELAY : ST_WAIT_ARM;
                end
            end
            ST_DELAY: begin
                if (dly_done) begin
                    fire    = 1'b1;
                    state_d = ST_ON;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (!enable_i) begin
            state_d = ST_IDLE;
            fire    = 1'b0;
        end
    end

    always_comb begin
        blank_start = !enable_i || ((state_q == ST_ON) && (state_d == ST_BLANK));
        dly_start   = (state_q == ST_WAIT_TRIG) && (state_d == ST_DELAY);
        armed       = (state_q == ST_WAIT_TRIG);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= fire;
        end
    end

    assign gate_on_o = gate_q && enable_i;

    AST_GATE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |=> !gate_q) else $error("gate pulse too long");  // R9

    AST_EARLY_VALLEY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && enable_i && !zcd_trig_i && !lim_done && !fallback_due) |=> (state_q == ST_WAIT_ARM))
        else $error("early valley kept");  // R2

    AST_ON_AFTER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY) |-> lim_done) else $error("delay before limit");  // R3

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> ((state_q == ST_IDLE) && !gate_q)) else $error("not idle when disabled");  // R11

    AST_OFF_ONLY_IN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && pwm_off_i && (state_q == ST_WAIT_ARM) && !starter_due && !zcd_arm_i)
        |=> (state_q == ST_WAIT_ARM)) else $error("turn-off honoured outside ON");  // R10

endmodule

// File: tb/test_qr_turnon_ctrl.sv
module test_qr_turnon_ctrl;

    localparam int LIM   = 12;
    localparam int BS    = 4;
    localparam int BL    = 20;
    localparam int STB   = 2;
    localparam int DLY   = 3;
    localparam int TON   = 4;
    localparam int NROWS = 9;

    // columns: long_blank, ring_start(0 = none), hi_len, lo_len, extra_off_edge, expected_edge
    localparam int TBL [NROWS][6] = '{
        '{0,  9,    2, 2,  0,  18},   // R2 first valley skipped
        '{0, 12,    2, 2,  0,  17},   // R1 R4 R6 first valley taken
        '{1,  9,    2, 2,  0,  30},   // R5 valleys inside long blank ignored
        '{0, 10,    3, 5,  0,  16},   // R3 valley exactly at limit
        '{0,  9,    3, 5,  0,  23},   // R3 valley one edge early
        '{0, 12,    2, 2, 11,  17},   // R10 stray turn-off ignored
        '{0,  0,    1, 1,  0,  97},   // R7 starter
        '{0,  9, 2000, 1,  0, 769},   // R8 permanent arm fallback
        '{0,  5,    2, 2,  0,  18}    // R2 R4 ring across short blank
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable_i = 1'b0;
    logic zcd_arm_i = 1'b0;
    logic zcd_trig_i = 1'b0;
    logic zcd_lvl_i = 1'b1;
    logic pwm_off_i = 1'b0;
    logic gate_on_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    qr_turnon_ctrl #(
        .LIM_CYC         (LIM),
        .BLANK_SHORT_CYC (BS),
        .BLANK_LONG_CYC  (BL),
        .STROBE_CYC      (STB),
        .DELAY_CYC       (DLY)
    ) i_qr_turnon_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .zcd_arm_i  (zcd_arm_i),
        .zcd_trig_i (zcd_trig_i),
        .zcd_lvl_i  (zcd_lvl_i),
        .pwm_off_i  (pwm_off_i),
        .gate_on_o  (gate_on_o)
    );

    function automatic string row_tag(int r);
        case (r)
            0: return "R2";
            1: return "R1";
            2: return "R5";
            3: return "R3";
            4: return "R3";
            5: return "R10";
            6: return "R7";
            7: return "R8";
            default: return "R4";
        endcase
    endfunction

    function automatic bit ring_hi(int n, int s0, int h, int l);
        if (s0 == 0 || n < s0) return 1'b0;
        return ((n - s0) % (h + l)) < h;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // walk from a turn-on (edge 0) to the next one; returns edge index or -1
    task automatic run_ring(int lng, int s0, int h, int l, int xoff, int limit, output int got);
        int m = 0;
        got = -1;
        zcd_lvl_i = !lng;
        while (m < limit) begin
            pwm_off_i  = ((m + 1) == TON) || ((m + 1) == xoff);
            zcd_arm_i  = ring_hi(m + 1, s0, h, l);
            zcd_trig_i = ring_hi(m + 1, s0, h, l);
            @(negedge clk);
            m++;
            if (gate_on_o) begin
                got = m;
                break;
            end
        end
        pwm_off_i = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done_flag) begin
            done_flag = 1'b1;
            checks++;
            fails++;
            $display("FAIL R12 watchdog: cycles=%0d expected<=%0d", cycles, 20000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int got;
        int m;
        // R12 reset state
        repeat (3) @(negedge clk);
        check("R12", "gate during reset", int'(gate_on_o), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R12", "gate while disabled", int'(gate_on_o), 0);

        // R7 start-up by starter from first enabled edge
        enable_i = 1'b1;
        m = -1;
        got = -1;
        while (m < 200) begin
            @(negedge clk);
            m++;
            if (gate_on_o) begin
                got = m;
                break;
            end
        end
        check("R7", "start-up starter edge", got, 8 * LIM + 1);

        // table walk
        for (int r = 0; r < NROWS; r++) begin
            run_ring(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], TBL[r][4], TBL[r][5] + 40, got);
            check(row_tag(r), $sformatf("row %0d turn-on edge", r), got, TBL[r][5]);
        end

        // R9 pulse is one cycle wide (last row just fired)
        @(negedge clk);
        check("R9", "gate one cycle wide", int'(gate_on_o), 0);

        // R11: disable in the very cycle the pulse would appear (ring as row 1, edge 17)
        zcd_lvl_i = 1'b1;
        m = 1;
        while (m <= 16) begin
            pwm_off_i  = ((m + 1) == TON);
            zcd_arm_i  = ring_hi(m + 1, 12, 2, 2);
            zcd_trig_i = ring_hi(m + 1, 12, 2, 2);
            @(negedge clk);
            m++;
        end
        pwm_off_i = 1'b0;
        @(posedge clk);
        #1 enable_i = 1'b0;
        @(negedge clk);
        check("R11", "gate forced low by disable", int'(gate_on_o), 0);
        zcd_arm_i  = 1'b0;
        zcd_trig_i = 1'b0;
        got = 0;
        repeat (30) begin
            @(negedge clk);
            if (gate_on_o) got = 1;
        end
        check("R11", "no gate while disabled", got, 0);
        enable_i = 1'b1;
        m = -1;
        got = -1;
        while (m < 200) begin
            @(negedge clk);
            m++;
            if (gate_on_o) begin
                got = m;
                break;
            end
        end
        check("R11", "phase restarted on enable", got, 8 * LIM + 1);

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule